// File: doc/BRIEF.md
# USB Low-Speed Packet Receiver

This block turns the two single-ended lines of a low-speed USB link into a stream of decoded bytes. It runs from a system clock that oversamples the bus by a non-integer ratio (32/3 clocks per bit by default). After reset, or after the previous packet, it waits for the bus to go idle. It then finds the sync field by watching the falling edges of D−. It locks its sampling phase to the final K-K pair of the sync field and from then on samples one point per bit period.

Each sampled level is NRZI-decoded. A bit that follows six decoded ones is discarded as a stuffed bit. Decoded bits are gathered into bytes, least significant bit first. Every complete byte is presented with a one-clock strobe and the running count of bytes in the packet. An SE0 at any data sample ends the packet with a done pulse, the final count and a partial-byte flag. A packet that goes past the byte limit is cut off with an overflow pulse instead.

Top module: `usbls_rx`

## Requirements
- R1: Line states are read as {D+, D−}: J = 01 (idle), K = 10, SE0 = 00. Both lines pass through a two-flop synchronizer before any decision is made on them.
- R2: After reset and after each packet, the receiver takes no action until D− is high, with no timeout. An SE0 held for any length of time produces no output.
- R3: A falling D− edge starts a sync check. The line must read K half a bit later, otherwise the search restarts, so a K shorter than half a bit is ignored. Sync completes when the sample one bit after that is also K. If that sample is J, the search restarts at the next falling edge.
- R4: Data bit k (k = 1, 2, …) is sampled exactly floor(k·BIT_NUM/BIT_DEN) clocks after the final sync K sample. Consecutive data samples are therefore BASE or BASE+1 clocks apart, where BASE = floor(BIT_NUM/BIT_DEN).
- R5: NRZI decoding gives 1 when the sampled level equals the previous sample and 0 when it differs. The first comparison is made against the final sync K.
- R6: When the six previous decoded bits are all 1, the next bit is discarded. That bit is not counted, and the ones-history is cleared.
- R7: Bytes are assembled LSb first. Each complete byte appears on `byte_o` with a one-clock `byte_vld_o`, and `byte_cnt_o` then holds the 1-based index of that byte in the packet. The sync byte is never output, and the count restarts at 0 with each sync.
- R8: An SE0 seen at a data sample ends the packet. `done_o` pulses for one clock and `byte_cnt_o` holds the number of complete bytes. `partial_o` pulses together with `done_o` exactly when bits were received after the last complete byte.
- R9: When byte MAX_BYTES+1 completes, `ovf_o` pulses for one clock. That byte is not output, no `done_o` follows for the packet, and the receiver ignores the line until it sees an SE0, then waits for idle.
- R10: `byte_vld_o`, `done_o` and `ovf_o` never pulse in the same clock.
- R11: During and right after reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oversampling system clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| dp_i | input | 1 | Raw D+ line level |
| dm_i | input | 1 | Raw D− line level |
| byte_o | output | 8 | Last decoded byte |
| byte_vld_o | output | 1 | One-clock strobe for a new byte |
| byte_cnt_o | output | $clog2(MAX_BYTES+1) | Bytes received in the current packet |
| done_o | output | 1 | One-clock end-of-packet pulse |
| partial_o | output | 1 | With `done_o`: a partial byte was pending |
| ovf_o | output | 1 | One-clock pulse when the byte limit is exceeded |

## Verification
The assertions assume that line transitions are spaced by whole bit periods of the nominal rate. Under that assumption, data samples never come closer than eight per byte, and a packet's count rises by exactly one per strobe. The stimulus builds every bit boundary from floor(i·BIT_NUM/BIT_DEN) clock offsets at the nominal rate. Each packet always ends with a two-bit SE0 followed by J, so the link never runs faster or slower than the rate the sample spacing check expects. The only deliberately short events are the sub-half-bit K glitch and the truncated sync, and both are rejected before data sampling starts.

// File: rtl/usbls_pkg.sv
package usbls_pkg;

    // Line encoding {D+, D-}
    localparam logic [1:0] LN_SE0 = 2'b00;
    localparam logic [1:0] LN_J   = 2'b01;
    localparam logic [1:0] LN_K   = 2'b10;

    typedef enum logic [2:0] {
        S_WAIT_J,   // wait for D- high, no timeout
        S_HUNT,     // wait for J->K falling edge of D-
        S_CHK1,     // confirm K at mid-bit
        S_CHK2,     // one bit later: K completes sync, J retries
        S_DATA,     // receive data bits
        S_DRAIN     // after overflow, wait for SE0
    } rx_state_e;

endpackage

// File: rtl/usbls_sync2.sv
module usbls_sync2 #(
    parameter int          WIDTH   = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic meta_q, meta_d;
        logic out_q, out_d;

        always_comb begin
            meta_d = async_i[g];
            out_d  = meta_q;
        end

        always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
                meta_q <= RST_VAL[g];
                out_q  <= RST_VAL[g];
            end else begin
                meta_q <= meta_d;
                out_q  <= out_d;
            end
        end

        assign sync_o[g] = out_q;
    end

endmodule

// File: rtl/usbls_leap_timer.sv
module usbls_leap_timer #(
    parameter int BIT_NUM = 32,
    parameter int BIT_DEN = 3,
    localparam int BASE   = BIT_NUM / BIT_DEN,
    localparam int REM    = BIT_NUM % BIT_DEN,
    localparam int CW     = $clog2(BASE + 2),
    localparam int AW     = $clog2(2 * BIT_DEN + 1)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          restart_i,
    input  logic [CW-1:0] restart_len_i,
    output logic          tick_o
);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [AW-1:0] acc;
    } tmr_t;

    tmr_t tq, td;
    logic [AW-1:0] sum;

    assign tick_o = (tq.cnt == '0);
    assign sum    = tq.acc + AW'(REM);

    always_comb begin
        td = tq;
        if (restart_i) begin
            td.cnt = restart_len_i - CW'(1);
            td.acc = AW'(REM);
        end else if (tick_o) begin
            if (sum >= AW'(BIT_DEN)) begin
                td.acc = sum - AW'(BIT_DEN);
                td.cnt = CW'(BASE);          // leap slot: BASE+1 clocks
            end else begin
                td.acc = sum;
                td.cnt = CW'(BASE - 1);      // short slot: BASE clocks
            end
        end else begin
            td.cnt = tq.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            tq.cnt <= CW'(BASE - 1);
            tq.acc <= '0;
        end else begin
            tq <= td;
        end
    end

endmodule

// File: rtl/usbls_destuff.sv
module usbls_destuff #(
    parameter int RUN = 6
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic init_i,   // load previous level = K, clear history
    input  logic smp_i,    // a non-SE0 data sample this clock
    input  logic lvl_i,    // D+ level of the sample
    output logic bit_vld_o,
    output logic bit_o
);

    typedef struct packed {
        logic           prev;
        logic [RUN-1:0] hist;
    } ds_t;

    ds_t sq, sd;
    logic stuffed;

    assign bit_o     = (lvl_i == sq.prev);
    assign stuffed   = &sq.hist;
    assign bit_vld_o = smp_i && !stuffed;

    always_comb begin
        sd = sq;
        if (init_i) begin
            sd.prev = 1'b1;
            sd.hist = '0;
        end else if (smp_i) begin
            sd.prev = lvl_i;
            if (stuffed) begin
                sd.hist = '0;
            end else begin
                sd.hist = {sq.hist[RUN-2:0], bit_o};
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            sq.prev <= 1'b1;
            sq.hist <= '0;
        end else begin
            sq <= sd;
        end
    end

endmodule

// File: rtl/usbls_rx.sv
module usbls_rx
    import usbls_pkg::*;
#(
    parameter int BIT_NUM   = 32,
    parameter int BIT_DEN   = 3,
    parameter int MAX_BYTES = 8,
    localparam int BASE     = BIT_NUM / BIT_DEN,
    localparam int HALF     = BIT_NUM / (2 * BIT_DEN),
    localparam int CW       = $clog2(BASE + 2),
    localparam int CNT_W    = $clog2(MAX_BYTES + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             dp_i,
    input  logic             dm_i,
    output logic [7:0]       byte_o,
    output logic             byte_vld_o,
    output logic [CNT_W-1:0] byte_cnt_o,
    output logic             done_o,
    output logic             partial_o,
    output logic             ovf_o
);

    typedef struct packed {
        rx_state_e        st;
        logic [7:0]       shreg;
        logic [2:0]       nbits;
        logic [CNT_W-1:0] cnt;
        logic [7:0]       dout;
        logic             vld;
        logic             done;
        logic             part;
        logic             ovf;
    } rx_t;

    rx_t rq, rd;

    logic [1:0]    ln;
    logic          tick;
    logic          rx_act;
    logic          smp;
    logic          restart;
    logic [CW-1:0] restart_len;
    logic          ds_init;
    logic          bit_vld;
    logic          bit_val;
    logic [7:0]    nxt_byte;

    usbls_sync2 #(.WIDTH(2), .RST_VAL(LN_J)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i ({dp_i, dm_i}),
        .sync_o  (ln)
    );

    usbls_leap_timer #(.BIT_NUM(BIT_NUM), .BIT_DEN(BIT_DEN)) u_timer (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .restart_i     (restart),
        .restart_len_i (restart_len),
        .tick_o        (tick)
    );

    assign rx_act = (rq.st == S_DATA);
    assign smp    = rx_act && tick && (ln != LN_SE0);

    usbls_destuff #(.RUN(6)) u_destuff (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .init_i    (ds_init),
        .smp_i     (smp),
        .lvl_i     (ln[1]),
        .bit_vld_o (bit_vld),
        .bit_o     (bit_val)
    );

    assign nxt_byte = {bit_val, rq.shreg[7:1]};

    always_comb begin
        rd          = rq;
        rd.vld      = 1'b0;
        rd.done     = 1'b0;
        rd.part     = 1'b0;
        rd.ovf      = 1'b0;
        restart     = 1'b0;
        restart_len = CW'(BASE);
        ds_init     = 1'b0;

        unique case (rq.st)
            S_WAIT_J: begin
                if (ln[0]) rd.st = S_HUNT;
            end
            S_HUNT: begin
                if (!ln[0]) begin
                    restart     = 1'b1;
                    restart_len = CW'(HALF);
                    rd.st       = S_CHK1;
                end
            end
            S_CHK1: begin
                if (tick) begin
                    if (ln == LN_K) begin
                        restart = 1'b1;
                        rd.st   = S_CHK2;
                    end else begin
                        rd.st   = S_WAIT_J;
                    end
                end
            end
            S_CHK2: begin
                if (tick) begin
                    if (ln == LN_K) begin
                        restart  = 1'b1;
                        ds_init  = 1'b1;
                        rd.cnt   = '0;
                        rd.nbits = '0;
                        rd.st    = S_DATA;
                    end else begin
                        rd.st    = S_WAIT_J;
                    end
                end
            end
            S_DATA: begin
                if (tick) begin
                    if (ln == LN_SE0) begin
                        rd.done = 1'b1;
                        rd.part = (rq.nbits != '0);
                        rd.st   = S_WAIT_J;
                    end else if (bit_vld) begin
                        rd.shreg = nxt_byte;
                        rd.nbits = rq.nbits + 3'd1;
                        if (rq.nbits == 3'd7) begin
                            if (rq.cnt == CNT_W'(MAX_BYTES)) begin
                                rd.ovf = 1'b1;
                                rd.st  = S_DRAIN;
                            end else begin
                                rd.dout = nxt_byte;
                                rd.vld  = 1'b1;
                                rd.cnt  = rq.cnt + CNT_W'(1);
                            end
                        end
                    end
                end
            end
            S_DRAIN: begin
                if (ln == LN_SE0) rd.st = S_WAIT_J;
            end
            default: rd.st = S_WAIT_J;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            rq.st    <= S_WAIT_J;
            rq.shreg <= '0;
            rq.nbits <= '0;
            rq.cnt   <= '0;
            rq.dout  <= '0;
            rq.vld   <= 1'b0;
            rq.done  <= 1'b0;
            rq.part  <= 1'b0;
            rq.ovf   <= 1'b0;
        end else begin
            rq <= rd;
        end
    end

    assign byte_o     = rq.dout;
    assign byte_vld_o = rq.vld;
    assign byte_cnt_o = rq.cnt;
    assign done_o     = rq.done;
    assign partial_o  = rq.part;
    assign ovf_o      = rq.ovf;

endmodule

// File: rtl/usbls_rx_chk.sv
module usbls_rx_chk #(
    parameter int BIT_NUM   = 32,
    parameter int BIT_DEN   = 3,
    parameter int MAX_BYTES = 8,
    localparam int BASE     = BIT_NUM / BIT_DEN,
    localparam int GW       = $clog2(BASE + 3),
    localparam int CNT_W    = $clog2(MAX_BYTES + 1)
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             byte_vld_i,
    input logic [CNT_W-1:0] byte_cnt_i,
    input logic             done_i,
    input logic             partial_i,
    input logic             ovf_i,
    input logic             tick_i,
    input logic             rx_act_i
);

    logic [GW-1:0] gap_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            gap_q <= '0;
        end else if (tick_i) begin
            gap_q <= GW'(1);
        end else if (gap_q != GW'(BASE + 2)) begin
            gap_q <= gap_q + GW'(1);
        end
    end

    p_sample_gap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && rx_act_i) |-> (gap_q == GW'(BASE) || gap_q == GW'(BASE + 1)));

    p_vld_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        byte_vld_i |=> !byte_vld_i);

    p_cnt_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        byte_vld_i |-> (byte_cnt_i == CNT_W'($past(byte_cnt_i) + 1'b1)));

    p_part_with_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        partial_i |-> done_i);

    p_cnt_cap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        byte_cnt_i <= CNT_W'(MAX_BYTES));

    p_ovf_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ovf_i |=> (!done_i && !byte_vld_i));

    p_pulse_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({byte_vld_i, done_i, ovf_i}));

endmodule

bind usbls_rx usbls_rx_chk #(
    .BIT_NUM   (BIT_NUM),
    .BIT_DEN   (BIT_DEN),
    .MAX_BYTES (MAX_BYTES)
) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .byte_vld_i (byte_vld_o),
    .byte_cnt_i (byte_cnt_o),
    .done_i     (done_o),
    .partial_i  (partial_o),
    .ovf_i      (ovf_o),
    .tick_i     (tick),
    .rx_act_i   (rx_act)
);

// File: tb/sim_usbls_rx.sv
`timescale 1ns/1ps
module sim_usbls_rx;

    localparam int N     = 32;
    localparam int D     = 3;
    localparam int MAXB  = 8;
    localparam int CNT_W = $clog2(MAXB + 1);

    localparam logic [1:0] L_J   = 2'b01;
    localparam logic [1:0] L_K   = 2'b10;
    localparam logic [1:0] L_SE0 = 2'b00;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             dp = 1'b0;
    logic             dm = 1'b1;
    logic [7:0]       byte_o;
    logic             byte_vld;
    logic [CNT_W-1:0] byte_cnt;
    logic             done;
    logic             partial;
    logic             ovf;

    always #2.5 clk = ~clk;

    usbls_rx #(.BIT_NUM(N), .BIT_DEN(D), .MAX_BYTES(MAXB)) u0 (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .dp_i       (dp),
        .dm_i       (dm),
        .byte_o     (byte_o),
        .byte_vld_o (byte_vld),
        .byte_cnt_o (byte_cnt),
        .done_o     (done),
        .partial_o  (partial),
        .ovf_o      (ovf)
    );

    int n_chk = 0;
    int n_fail = 0;

    typedef struct {
        logic [7:0] b;
        int         c;
    } exp_t;

    exp_t       exp_q[$];
    logic [7:0] pk[$];
    bit         done_seen, ovf_seen, part_seen;
    int         done_cnt;
    int         nb;

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    // reference comparison on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (byte_vld) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R7 unexpected byte", int'(byte_o), -1);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(byte_o == e.b, "R7 byte value", int'(byte_o), int'(e.b));
                    check(int'(byte_cnt) == e.c, "R7 running count", int'(byte_cnt), e.c);
                end
            end
            if (done) begin
                done_seen = 1'b1;
                done_cnt  = int'(byte_cnt);
                part_seen = partial;
            end
            if (ovf) ovf_seen = 1'b1;
        end
    end

    task automatic put(input logic [1:0] lv);
        int len;
        len = ((nb + 1) * N) / D - (nb * N) / D;
        {dp, dm} = lv;
        nb++;
        repeat (len) @(negedge clk);
    endtask

    task automatic idle(input int cycles);
        {dp, dm} = L_J;
        repeat (cycles) @(negedge clk);
    endtask

    task automatic clear_seen();
        exp_q.delete();
        done_seen = 1'b0;
        ovf_seen  = 1'b0;
        part_seen = 1'b0;
        done_cnt  = -1;
    endtask

    // sends the bytes in pk plus nx trailing bits of xb
    task automatic send_packet(input int nx, input logic [7:0] xb);
        logic lvl;
        int   ones;
        bit   bits[$];
        nb = 0;
        put(L_K); put(L_J); put(L_K); put(L_J);
        put(L_K); put(L_J); put(L_K); put(L_K);
        lvl  = 1'b1;
        ones = 0;
        foreach (pk[i]) for (int j = 0; j < 8; j++) bits.push_back(pk[i][j]);
        for (int j = 0; j < nx; j++) bits.push_back(xb[j]);
        foreach (bits[i]) begin
            if (!bits[i]) lvl = ~lvl;
            put({lvl, ~lvl});
            ones = bits[i] ? ones + 1 : 0;
            if (ones == 6) begin
                lvl = ~lvl;
                put({lvl, ~lvl});
                ones = 0;
            end
        end
        put(L_SE0); put(L_SE0); put(L_J);
    endtask

    task automatic run_packet(input string tag, input int nx, input logic [7:0] xb);
        int sz;
        clear_seen();
        sz = pk.size();
        for (int i = 0; i < sz && i < MAXB; i++) begin
            exp_t e;
            e.b = pk[i];
            e.c = i + 1;
            exp_q.push_back(e);
        end
        send_packet(nx, xb);
        idle(30);
        check(exp_q.size() == 0, {tag, " R7 all bytes delivered"}, exp_q.size(), 0);
        if (sz > MAXB) begin
            check(ovf_seen, {tag, " R9 overflow flagged"}, int'(ovf_seen), 1);
            check(!done_seen, {tag, " R9 no done after overflow"}, int'(done_seen), 0);
        end else begin
            check(done_seen, {tag, " R8 done pulse"}, int'(done_seen), 1);
            check(done_cnt == sz, {tag, " R8 final count"}, done_cnt, sz);
            check(part_seen == (nx > 0), {tag, " R8 partial flag"}, int'(part_seen), int'(nx > 0));
            check(!ovf_seen, {tag, " R9 no overflow"}, int'(ovf_seen), 0);
        end
    endtask

    task automatic expect_quiet(input string tag);
        check(!done_seen && !ovf_seen, tag, int'(done_seen) + int'(ovf_seen), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R11: reset state
        rst_n = 1'b0;
        {dp, dm} = L_J;
        repeat (4) @(negedge clk);
        check({byte_vld, done, partial, ovf} == 4'b0, "R11 pulses low in reset",
              int'({byte_vld, done, partial, ovf}), 0);
        check(byte_cnt == '0 && byte_o == 8'h00, "R11 data zero in reset",
              int'(byte_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check({byte_vld, done, partial, ovf} == 4'b0, "R11 pulses low after reset",
              int'({byte_vld, done, partial, ovf}), 0);
        idle(20);

        // R1 R5 R7 R8: plain packet
        pk = '{8'hC3, 8'h5A, 8'h01};
        run_packet("plain", 0, 8'h00);

        // R6: long runs of ones force stuffing, including at the end
        pk = '{8'hFF, 8'hFF, 8'h7E, 8'h3F};
        run_packet("R6 stuffing", 0, 8'h00);

        // R8: trailing partial byte
        pk = '{8'h12};
        run_packet("R8 partial", 3, 8'h05);

        // R8: empty packet
        pk.delete();
        run_packet("R8 empty", 0, 8'h00);

        // R4: full buffer of alternating patterns accumulates any timing error
        pk.delete();
        for (int i = 0; i < MAXB; i++) pk.push_back(8'(i * 37 + 1));
        run_packet("R4 full length", 0, 8'h00);
        pk = '{8'h00, 8'h00, 8'h00, 8'h00};
        run_packet("R4 all transitions", 0, 8'h00);

        // R9: overflow, then recovery
        pk.delete();
        for (int i = 0; i < MAXB + 2; i++) pk.push_back(8'(8'hA0 + i));
        run_packet("R9 overflow", 0, 8'h00);
        pk = '{8'h3C};
        run_packet("R9 recovery", 0, 8'h00);

        // R2: SE0 held long gives nothing, then a packet is received
        clear_seen();
        {dp, dm} = L_SE0;
        repeat (150) @(negedge clk);
        expect_quiet("R2 held SE0 ignored");
        idle(20);
        pk = '{8'hA5};
        run_packet("R2 after long SE0", 0, 8'h00);

        // R3: short K glitch is rejected
        clear_seen();
        {dp, dm} = L_K;
        repeat (2) @(negedge clk);
        idle(60);
        expect_quiet("R3 short K glitch ignored");

        // R3: truncated sync field with no double K
        clear_seen();
        nb = 0;
        put(L_K); put(L_J); put(L_K); put(L_J);
        idle(80);
        expect_quiet("R3 no double K no sync");

        // R3 R5: receiver still locks afterwards
        pk = '{8'h80, 8'h7F};
        run_packet("R3 relock", 0, 8'h00);

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule